// File: doc/BRIEF.md
# 1-Wire Slave Bit Slot Engine

This block carries the bit-level traffic of a 1-Wire slave once the bus reset and presence exchange are over. The master opens every time slot by pulling the shared line low. Each accepted falling edge starts one internal delay timer, and that timer alone sets the timing of the slot. In a write slot, the block samples the line when the delay runs out and reports the bit with a one-cycle strobe. In a read slot, the block takes a bit from its transmit input. It pulls the line low for the whole delay to send a 0 and leaves the line released to send a 1. It then reports that the bit has gone out with a one-cycle acknowledge.

A direction input, sampled when the slot opens, selects the slot type. The nominal delay is 30 µs and is converted to clock cycles from the `CLK_HZ` parameter. A falling edge counts only after the line has stayed high for a minimum recovery time, and an edge that arrives while a slot is running is ignored. An external strobe, raised when a bus reset is detected, cancels any slot in progress. Byte assembly and bit order are left to the layer above, which presents and collects one bit per slot, least significant first.

Top module: `ow_slot_engine`

## Requirements
- R1: While reset is held and right after it is released, `lineDriveLow`, `rxValid` and `txAck` are all 0.
- R2: In a write slot (`slotIsRead`=0 at slot start), `rxValid` pulses D+2 clock edges after the first edge that sees `lineIn` low, where D = CLK_HZ·SAMPLE_US/10^6. `rxBit` is 1 if the master released the line well before that point and 0 if it still holds the line low.
- R3: `rxValid` is never high for two cycles in a row, and one write slot gives exactly one pulse.
- R4: In a read slot with `txBit`=0, `lineDriveLow` goes high two edges after the first low sample and stays high for exactly D cycles. It drops in the same cycle that `txAck` pulses.
- R5: In a read slot with `txBit`=1, `lineDriveLow` stays 0 for the whole slot, and `txAck` still pulses at the same point as in R4.
- R6: `txAck` pulses once per read slot and never in a write slot. `rxValid` never pulses in a read slot, and the two strobes are never high together.
- R7: A falling edge that arrives while a slot is running neither restarts the timer nor opens a second slot.
- R8: A falling edge counts only when the synchronised line has been high for at least REC = CLK_HZ·RECOV_US/10^6 cycles before it. An edge after a shorter high period starts no slot, and this also applies right after reset.
- R9: A `busResetSeen` pulse ends any slot. On the next cycle `lineDriveLow`, `rxValid` and `txAck` are 0, and no strobe follows for the cancelled slot.
- R10: `slotIsRead` and `txBit` are captured when the slot opens. Changing them while the slot runs does not change the slot's type, the level driven on the line or the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Level of the shared 1-Wire line (asynchronous) |
| slotIsRead | input | 1 | 1 = the next slot is a read slot (slave sends), 0 = write slot |
| txBit | input | 1 | Bit to send in the next read slot |
| busResetSeen | input | 1 | Strobe from the reset detector that aborts the slot |
| lineDriveLow | output | 1 | 1 = pull the line low (open-drain enable) |
| rxBit | output | 1 | Bit sampled in the last write slot |
| rxValid | output | 1 | One-cycle strobe marking a new `rxBit` |
| txAck | output | 1 | One-cycle strobe at the end of a read slot |

## Verification
All slot timing is counted from the first clock edge that registers the line low. The two-flop synchroniser and the edge detector take two edges. The timer is then loaded with D−1 and counts to zero. The final action is registered. Together these put `rxValid` and `txAck` on edge D+2 after the first low sample, and put a driven 0 on the line from edge 2 to edge D+2. The bench walks through every slot one falling clock edge at a time. It records the index at which each strobe and each driven cycle appears and compares those indices with the values computed from D. The line levels it drives for write slots stay at least ten cycles away from the sample point, so the expected bit cannot depend on one cycle of synchroniser latency.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_WRITE = 2'd1,
    SLOT_READ  = 2'd2
  } slotState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic startSlot;  // load the delay timer
    logic holdLine;   // begin pulling the line low
    logic dropLine;   // release the line
    logic sampleBit;  // capture the line into rxBit
    logic endRead;    // read slot finished
  } slotCtl_t;

  function automatic int usToCycles(input int clkHz, input int us);
    longint prod;
    prod = (longint'(clkHz) * longint'(us)) / 64'sd1000000;
    return (prod < 1) ? 1 : int'(prod);
  endfunction

endpackage

// File: rtl/ow_slot_datapath.sv
module ow_slot_datapath
  import ow_slot_pkg::*;
#(
  parameter int DELAY_CYC = 60,
  parameter int REC_CYC   = 10
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineIn,
  input  slotCtl_t ctl,
  output logic     fallEvt,
  output logic     timerDone,
  output logic     lineDriveLow,
  output logic     rxBit,
  output logic     rxValid,
  output logic     txAck
);

  localparam int TW = $clog2(DELAY_CYC + 1);
  localparam int HW = $clog2(REC_CYC + 1);
  localparam logic [TW-1:0] TIMER_LOAD = TW'(DELAY_CYC - 1);
  localparam logic [HW-1:0] HIGH_FULL  = HW'(REC_CYC);

  logic syncA, lineS, prevS;
  logic [HW-1:0] highCnt;
  logic [TW-1:0] timerQ;
  logic lineReady;

  // two-stage synchroniser plus one stage for edge detect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b1;
      lineS <= 1'b1;
      prevS <= 1'b1;
    end else begin
      syncA <= lineIn;
      lineS <= syncA;
      prevS <= lineS;
    end
  end

  // consecutive high samples, saturating at the recovery length
  always_ff @(posedge clk) begin
    if (!rstN) begin
      highCnt <= '0;
    end else if (!lineS) begin
      highCnt <= '0;
    end else if (highCnt != HIGH_FULL) begin
      highCnt <= highCnt + 1'b1;
    end
  end

  assign lineReady = (highCnt == HIGH_FULL);
  assign fallEvt   = prevS & ~lineS & lineReady;

  // single delay timer shared by both slot types
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (ctl.startSlot) begin
      timerQ <= TIMER_LOAD;
    end else if (timerQ != '0) begin
      timerQ <= timerQ - 1'b1;
    end
  end

  assign timerDone = (timerQ == '0);

  // open-drain enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineDriveLow <= 1'b0;
    end else if (ctl.holdLine) begin
      lineDriveLow <= 1'b1;
    end else if (ctl.dropLine) begin
      lineDriveLow <= 1'b0;
    end
  end

  // received bit and strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBit   <= 1'b0;
      rxValid <= 1'b0;
      txAck   <= 1'b0;
    end else begin
      rxValid <= ctl.sampleBit;
      txAck   <= ctl.endRead;
      if (ctl.sampleBit) begin
        rxBit <= lineS;
      end
    end
  end

endmodule

// File: rtl/ow_slot_ctrl.sv
module ow_slot_ctrl
  import ow_slot_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     fallEvt,
  input  logic     timerDone,
  input  logic     slotIsRead,
  input  logic     txBit,
  input  logic     busResetSeen,
  output slotCtl_t ctl
);

  slotState_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= SLOT_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  always_comb begin
    stateD = stateQ;
    ctl    = '0;
    unique case (stateQ)
      SLOT_IDLE: begin
        if (!busResetSeen && fallEvt) begin
          ctl.startSlot = 1'b1;
          ctl.holdLine  = slotIsRead & ~txBit;
          stateD        = slotIsRead ? SLOT_READ : SLOT_WRITE;
        end
      end
      SLOT_WRITE: begin
        if (busResetSeen) begin
          stateD = SLOT_IDLE;
        end else if (timerDone) begin
          ctl.sampleBit = 1'b1;
          stateD        = SLOT_IDLE;
        end
      end
      SLOT_READ: begin
        if (busResetSeen) begin
          ctl.dropLine = 1'b1;
          stateD       = SLOT_IDLE;
        end else if (timerDone) begin
          ctl.dropLine = 1'b1;
          ctl.endRead  = 1'b1;
          stateD       = SLOT_IDLE;
        end
      end
      default: begin
        ctl.dropLine = 1'b1;
        stateD       = SLOT_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_slot_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SAMPLE_US = 30,
  parameter int RECOV_US  = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  input  logic slotIsRead,
  input  logic txBit,
  input  logic busResetSeen,
  output logic lineDriveLow,
  output logic rxBit,
  output logic rxValid,
  output logic txAck
);

  localparam int DELAY_CYC = usToCycles(CLK_HZ, SAMPLE_US);
  localparam int REC_CYC   = usToCycles(CLK_HZ, RECOV_US);

  slotCtl_t ctl;
  logic     fallEvt;
  logic     timerDone;

  ow_slot_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .fallEvt      (fallEvt),
    .timerDone    (timerDone),
    .slotIsRead   (slotIsRead),
    .txBit        (txBit),
    .busResetSeen (busResetSeen),
    .ctl          (ctl)
  );

  ow_slot_datapath #(
    .DELAY_CYC (DELAY_CYC),
    .REC_CYC   (REC_CYC)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .lineIn       (lineIn),
    .ctl          (ctl),
    .fallEvt      (fallEvt),
    .timerDone    (timerDone),
    .lineDriveLow (lineDriveLow),
    .rxBit        (rxBit),
    .rxValid      (rxValid),
    .txAck        (txAck)
  );

endmodule

// File: rtl/ow_slot_checker.sv
module ow_slot_checker #(
  parameter int DELAY_CYC = 60
) (
  input logic clk,
  input logic rstN,
  input logic busResetSeen,
  input logic lineDriveLow,
  input logic rxValid,
  input logic txAck
);

  int driveRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      driveRun <= 0;
    end else if (lineDriveLow) begin
      driveRun <= driveRun + 1;
    end else begin
      driveRun <= 0;
    end
  end

  // R3
  rx_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R6
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    txAck |=> !txAck);

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && txAck));

  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busResetSeen |=> (!lineDriveLow && !rxValid && !txAck));

  // R4
  release_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(lineDriveLow) && !$past(busResetSeen)) |-> txAck);

  // R4
  hold_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineDriveLow |-> (driveRun < DELAY_CYC));

endmodule

bind ow_slot_engine ow_slot_checker #(
  .DELAY_CYC (DELAY_CYC)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .busResetSeen (busResetSeen),
  .lineDriveLow (lineDriveLow),
  .rxValid      (rxValid),
  .txAck        (txAck)
);

// File: tb/sim_ow_slot_engine.sv
module sim_ow_slot_engine;

  localparam int CLK_HZ    = 2_000_000;  // scaled so a slot fits a short run
  localparam int SAMPLE_US = 30;
  localparam int RECOV_US  = 5;
  localparam int D   = CLK_HZ / 1_000_000 * SAMPLE_US;
  localparam int REC = CLK_HZ / 1_000_000 * RECOV_US;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterLow = 1'b1;
  logic slotIsRead = 1'b0;
  logic txBit = 1'b1;
  logic busResetSeen = 1'b0;
  logic lineIn;
  logic lineDriveLow, rxBit, rxValid, txAck;

  int nRun = 0;
  int nFail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  assign lineIn = !(masterLow || lineDriveLow);

  ow_slot_engine #(
    .CLK_HZ    (CLK_HZ),
    .SAMPLE_US (SAMPLE_US),
    .RECOV_US  (RECOV_US)
  ) u0 (
    .clk          (clk),
    .rstN         (rstN),
    .lineIn       (lineIn),
    .slotIsRead   (slotIsRead),
    .txBit        (txBit),
    .busResetSeen (busResetSeen),
    .lineDriveLow (lineDriveLow),
    .rxBit        (rxBit),
    .rxValid      (rxValid),
    .txAck        (txAck)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expRxBit(input int lowLen);
    return (lowLen >= D) ? 0 : 1;
  endfunction

  // One slot, stepped on falling clock edges; k counts negedges since the line fell.
  task automatic runSlot(input bit isRead, input bit txb, input int lowLen,
                         input int repAt, input int repLen,
                         input int abortAt, input int flipAt);
    int rxCnt = 0, rxAt = 0, rxVal = 0;
    int txCnt = 0, txAt = 0;
    int drvCnt = 0, drvFirst = 0, drvLast = 0;
    int endK;
    endK = lowLen;
    if (repAt + repLen > endK) endK = repAt + repLen;
    if (D + 3 > endK) endK = D + 3;
    endK = endK + REC + 8;
    slotIsRead = isRead;
    txBit = txb;
    masterLow = 1'b1;
    for (int k = 1; k <= endK; k++) begin
      @(negedge clk);
      if (rxValid) begin rxCnt++; rxAt = k; rxVal = int'(rxBit); end
      if (txAck) begin txCnt++; txAt = k; end
      if (lineDriveLow) begin
        drvCnt++;
        if (drvFirst == 0) drvFirst = k;
        drvLast = k;
      end
      masterLow = (k < lowLen) || (repAt > 0 && k >= repAt && k < repAt + repLen);
      busResetSeen = (abortAt > 0 && k == abortAt);
      if (flipAt > 0 && k == flipAt) begin
        slotIsRead = ~isRead;
        txBit = ~txb;
      end
    end
    busResetSeen = 1'b0;
    if (abortAt > 0) begin
      chk(rxCnt == 0, "R9 no rxValid after abort", rxCnt, 0);
      chk(txCnt == 0, "R9 no txAck after abort", txCnt, 0);
      if (drvCnt > 0) chk(drvLast == abortAt, "R9 line released after abort", drvLast, abortAt);
    end else if (!isRead) begin
      chk(rxCnt == 1, "R3 one rxValid per write slot", rxCnt, 1);
      chk(rxAt == D + 3, "R2 rxValid timing", rxAt, D + 3);
      chk(rxVal == expRxBit(lowLen), "R2 rxBit value", rxVal, expRxBit(lowLen));
      chk(txCnt == 0, "R6 no txAck in write slot", txCnt, 0);
      chk(drvCnt == 0, "R10 no drive in write slot", drvCnt, 0);
    end else begin
      chk(txCnt == 1, "R6 one txAck per read slot", txCnt, 1);
      chk(txAt == D + 3, "R6 txAck timing", txAt, D + 3);
      chk(rxCnt == 0, "R6 no rxValid in read slot", rxCnt, 0);
      if (!txb) begin
        chk(drvCnt == D, "R4 drive length", drvCnt, D);
        chk(drvFirst == 3, "R4 drive start", drvFirst, 3);
      end else begin
        chk(drvCnt == 0, "R5 no drive for a 1", drvCnt, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int seenAny;
    void'($urandom(32'h5EED_0A17));
    repeat (5) @(negedge clk);
    chk(!lineDriveLow && !rxValid && !txAck, "R1 state in reset",
        int'(lineDriveLow) + int'(rxValid) + int'(txAck), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!lineDriveLow && !rxValid && !txAck, "R1 state after reset",
        int'(lineDriveLow) + int'(rxValid) + int'(txAck), 0);

    // R8: short high after reset, then a fall; no slot may open
    masterLow = 1'b0;
    repeat (3) @(negedge clk);
    masterLow = 1'b1;
    seenAny = 0;
    repeat (D + 20) begin
      @(negedge clk);
      if (rxValid || txAck || lineDriveLow) seenAny++;
    end
    chk(seenAny == 0, "R8 fall after short recovery ignored", seenAny, 0);
    masterLow = 1'b0;
    repeat (REC + 8) @(negedge clk);

    // directed slots
    runSlot(1'b0, 1'b1, 5, 0, 0, 0, 0);          // R2 write 1
    runSlot(1'b0, 1'b1, 2 * D, 0, 0, 0, 0);      // R2 write 0
    runSlot(1'b1, 1'b0, 3, 0, 0, 0, 0);          // R4 read 0
    runSlot(1'b1, 1'b1, 3, 0, 0, 0, 0);          // R5 read 1
    runSlot(1'b0, 1'b1, 5, 25, 3, 0, 0);         // R7 second fall mid-slot
    runSlot(1'b1, 1'b0, 3, 25, 3, 0, 0);         // R7 in a read slot
    runSlot(1'b0, 1'b0, D + 20, D + 23, 40, 0, 0); // R8 refall after 3 high cycles
    runSlot(1'b1, 1'b0, 3, 0, 0, 20, 0);         // R9 abort read 0
    runSlot(1'b0, 1'b1, 5, 0, 0, 30, 0);         // R9 abort write
    runSlot(1'b1, 1'b0, 3, 0, 0, 0, 10);         // R10 flip inputs mid-slot
    runSlot(1'b0, 1'b1, 5, 0, 0, 0, 10);         // R10 flip inputs mid-slot

    // random slots
    for (int i = 0; i < 24; i++) begin
      bit isRd, tb;
      int lowLen;
      isRd = 1'($urandom_range(0, 1));
      tb = 1'($urandom_range(0, 1));
      if (isRd) lowLen = $urandom_range(2, 8);
      else if ($urandom_range(0, 1) == 1) lowLen = $urandom_range(2, D - 10);
      else lowLen = $urandom_range(D + 10, 2 * D);
      runSlot(isRd, tb, lowLen, 0, 0, 0, 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule